// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

A synchronous binary counter of parameterised width (four bits by default). It counts up or down and can be preset. Every state bit is updated together on the rising clock edge, and no bit clocks another. A low level on the load strobe makes the next edge copy the parallel data word into the count. This happens whatever the count enables and the direction input are doing. With load high, the count moves by one only when both active-low enables are low. The direction input picks the way: high counts up and low counts down.

The stage drives an active-low terminal carry. It is combinational and is low only in two cases. The first is enable T low, direction up and the count all ones. The second is enable T low, direction down and the count all zeros. The enable P input does not gate the carry, so a stage that is held by P still reports its terminal state to the next stage. To build a wider counter, wire each stage's carry to the T enable of the stage above it. Share the clock, P enable, direction and load among all stages. No extra gates are needed for the chain.

Top module: `updn_cascade_counter`

## Requirements
- R1: While load_n is 0 at a rising edge, q takes the value of din on that edge, whatever en_p_n, en_t_n and up are.
- R2: When load_n is 1, en_p_n is 0, en_t_n is 0 and up is 1 at a rising edge, q increases by one.
- R3: When load_n is 1, en_p_n is 0, en_t_n is 0 and up is 0 at a rising edge, q decreases by one.
- R4: When load_n is 1 and either en_p_n or en_t_n is 1 at a rising edge, q keeps its value.
- R5: carry_n is 0 exactly when en_t_n is 0 and either up is 1 with q all ones, or up is 0 with q all zeros. The carry follows its inputs without waiting for a clock edge, and en_p_n has no effect on it.
- R6: The count wraps. Counting up from all ones gives zero, and counting down from zero gives all ones.
- R7: Changes on load_n, en_p_n, en_t_n, up and din between rising edges do not change q. Only the levels present at the edge matter.
- R8: Two stages can be chained: the lower stage's carry_n drives the upper stage's en_t_n, and clock, en_p_n, up, load_n are shared. The pair then acts as one counter of twice the width. It steps by exactly one per enabled edge in both directions, and the step carries across the stage boundary.
- R9: Through a load, every bit of q can be set to 0 and to 1 independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| load_n | input | 1 | Active-low synchronous parallel load, highest priority |
| din | input | WIDTH | Parallel preset value |
| en_p_n | input | 1 | Active-low count enable that does not gate the carry |
| en_t_n | input | 1 | Active-low count enable that also gates the carry |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry, combinational |

## Verification
A load and a count request can arrive at the same edge, with load_n low while both enables are low. The random stimulus sets load_n low in about one cycle in eight, while the enables and direction keep moving on their own. Each such edge is judged against a bench model in which the load wins and the step is thrown away. In a two-stage chain, the upper stage's increment and the lower stage's wrap also fall on the same edge. Directed loads of 0x0F, 0xFF, 0xF0 and 0x00, counted in both directions, set this up, and the full 8-bit value is compared with the model's ±1 result.

// File: rtl/udc_pkg.sv
package udc_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_UP   = 2'd2,
      OP_DOWN = 2'd3
   } udc_op_e;

endpackage

// File: rtl/udc_ctl.sv
module udc_ctl
   import udc_pkg::*;
(
   input  logic    load_n,
   input  logic    en_p_n,
   input  logic    en_t_n,
   input  logic    up,
   output udc_op_e op
);
   always_comb begin
      if (!load_n)                  op = OP_LOAD;
      else if (!en_p_n && !en_t_n)  op = up ? OP_UP : OP_DOWN;
      else                          op = OP_HOLD;
   end
endmodule

// File: rtl/udc_step.sv
module udc_step #(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   output logic [WIDTH-1:0] nxt
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("udc_step: WIDTH must be at least 1");
      end
      if (LOOKAHEAD) begin : g_lookahead
         logic [WIDTH:0] all_one;
         logic [WIDTH:0] all_zero;
         assign all_one[0]  = 1'b1;
         assign all_zero[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign all_one[i+1]  = all_one[i] & cur[i];
            assign all_zero[i+1] = all_zero[i] & ~cur[i];
            assign nxt[i] = cur[i] ^ (up ? all_one[i] : all_zero[i]);
         end
      end else begin : g_adder
         localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
         assign nxt = up ? cur + ONE : cur - ONE;
      end
   endgenerate
endmodule

// File: rtl/udc_term.sv
module udc_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   input  logic             en_t_n,
   output logic             carry_n
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   logic at_end;
   assign at_end  = up ? (cur == TOP) : (cur == '0);
   assign carry_n = ~(at_end & ~en_t_n);
endmodule

// File: rtl/udc_state.sv
module udc_state
   import udc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  udc_op_e          op,
   input  logic [WIDTH-1:0] din,
   input  logic [WIDTH-1:0] stepped,
   output logic [WIDTH-1:0] q
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   always_ff @(posedge clk) begin
      unique case (op)
         OP_LOAD:         q <= din;
         OP_UP, OP_DOWN:  q <= stepped;
         default:         q <= q;
      endcase
   end

   logic live = 1'b0;
   always_ff @(posedge clk) live <= 1'b1;

   a_r1_load_wins: assert property (@(posedge clk) disable iff (!live)
      (op == OP_LOAD) |=> (q == $past(din)));
   a_r2_count_up: assert property (@(posedge clk) disable iff (!live)
      (op == OP_UP) |=> (q == $past(q) + ONE));
   a_r3_count_down: assert property (@(posedge clk) disable iff (!live)
      (op == OP_DOWN) |=> (q == $past(q) - ONE));
   a_r4_hold: assert property (@(posedge clk) disable iff (!live)
      (op == OP_HOLD) |=> $stable(q));
   a_r6_wrap_up: assert property (@(posedge clk) disable iff (!live)
      (op == OP_UP && q == TOP) |=> (q == '0));
   a_r6_wrap_down: assert property (@(posedge clk) disable iff (!live)
      (op == OP_DOWN && q == '0) |=> (q == TOP));
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
   import udc_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic [WIDTH-1:0] din,
   input  logic             en_p_n,
   input  logic             en_t_n,
   input  logic             up,
   output logic [WIDTH-1:0] q,
   output logic             carry_n
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   udc_op_e          op;
   logic [WIDTH-1:0] stepped;

   udc_ctl i_ctl (
      .load_n (load_n),
      .en_p_n (en_p_n),
      .en_t_n (en_t_n),
      .up     (up),
      .op     (op)
   );

   udc_step #(.WIDTH(WIDTH), .LOOKAHEAD(LOOKAHEAD)) i_step (
      .cur (q),
      .up  (up),
      .nxt (stepped)
   );

   udc_state #(.WIDTH(WIDTH)) i_state (
      .clk     (clk),
      .op      (op),
      .din     (din),
      .stepped (stepped),
      .q       (q)
   );

   udc_term #(.WIDTH(WIDTH)) i_term (
      .cur     (q),
      .up      (up),
      .en_t_n  (en_t_n),
      .carry_n (carry_n)
   );

   logic live = 1'b0;
   always_ff @(posedge clk) live <= 1'b1;

   a_r5_carry_needs_t: assert property (@(posedge clk) disable iff (!live)
      !carry_n |-> !en_t_n);
   a_r5_carry_up_end: assert property (@(posedge clk) disable iff (!live)
      (!en_t_n && up && q == TOP) |-> !carry_n);
   a_r5_carry_down_end: assert property (@(posedge clk) disable iff (!live)
      (!en_t_n && !up && q == '0) |-> !carry_n);
   a_r5_carry_mid: assert property (@(posedge clk) disable iff (!live)
      (q != TOP && q != '0) |-> carry_n);
endmodule

// File: tb/test_updn_cascade_counter.sv
module test_updn_cascade_counter;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         load_n = 1'b1, en_p_n = 1'b1, en_t_n = 1'b1, up = 1'b1;
   logic [7:0]   din8 = '0;
   logic [W-1:0] q_lo, q_hi;
   logic         c_lo, c_hi;

   int n_chk = 0, n_fail = 0;
   logic [7:0] model = '0;

   always #4 clk = ~clk;

   updn_cascade_counter #(.WIDTH(W)) i_updn_cascade_counter (
      .clk(clk), .load_n(load_n), .din(din8[3:0]), .en_p_n(en_p_n),
      .en_t_n(en_t_n), .up(up), .q(q_lo), .carry_n(c_lo));

   updn_cascade_counter #(.WIDTH(W), .LOOKAHEAD(1'b0)) i_updn_cascade_counter_hi (
      .clk(clk), .load_n(load_n), .din(din8[7:4]), .en_p_n(en_p_n),
      .en_t_n(c_lo), .up(up), .q(q_hi), .carry_n(c_hi));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic exp_carry(input logic [3:0] v, input logic t_n, input logic u);
      return !(!t_n && (u ? (v == 4'hF) : (v == 4'h0)));
   endfunction

   // One clock: drive at negedge, check carry, apply edge, check result.
   task automatic cyc(input logic ld, input logic pn, input logic tn, input logic u,
                      input logic [7:0] d, input logic glitch);
      logic [7:0] nxt;
      string tag;
      @(negedge clk);
      load_n = ld; en_p_n = pn; en_t_n = tn; up = u; din8 = d;
      #1;
      chk("R5", int'(c_lo), int'(exp_carry(model[3:0], tn, u)));
      if (glitch) begin
         #1 load_n = ~ld; en_p_n = ~pn; en_t_n = ~tn; up = ~u; din8 = ~d;
         #1 load_n = ld;  en_p_n = pn;  en_t_n = tn;  up = u;  din8 = d;
      end
      if (!ld) begin nxt = d; tag = "R1"; end
      else if (!pn && !tn) begin
         nxt = u ? model + 8'd1 : model - 8'd1;
         tag = u ? "R2" : "R3";
         if (u && model[3:0] == 4'hF) tag = "R6";
         if (!u && model[3:0] == 4'h0) tag = "R6";
      end else begin nxt = model; tag = "R4"; end
      if (glitch) tag = "R7";
      @(posedge clk);
      model = nxt;
      #2;
      chk(tag, int'(q_lo), int'(model[3:0]));
      chk("R8", int'({q_hi, q_lo}), int'(model));
   endtask

   initial begin : watchdog
      #(200000 * 8);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      r = $urandom(32'd1234);
      // initial state comes from a first load
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0);
      chk("R1", int'(q_lo), 0);
      // R9: each bit both ways
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0); chk("R9", int'({q_hi,q_lo}), 8'hA5);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 1'b0); chk("R9", int'({q_hi,q_lo}), 8'h5A);
      // R6 / R8 wrap both ways across the stage boundary
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0); chk("R6", int'({q_hi,q_lo}), 0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0); chk("R6", int'({q_hi,q_lo}), 8'hFF);
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h0F, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0); chk("R8", int'({q_hi,q_lo}), 8'h10);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0); chk("R8", int'({q_hi,q_lo}), 8'h0F);
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0); chk("R8", int'({q_hi,q_lo}), 8'hEF);
      // R4: hold by P, hold by T, with carry still reported when only P is high
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 8'h3F, 1'b0);
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0); chk("R4", int'({q_hi,q_lo}), 8'h3F);
      chk("R5", int'(c_lo), 0);
      cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0); chk("R4", int'({q_hi,q_lo}), 8'h3F);
      // R1: load beats an active count request
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 1'b0); chk("R1", int'({q_hi,q_lo}), 8'h77);
      // R7: mid-cycle toggles on all controls
      cyc(1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 1'b1);
      // long up run through several boundaries
      for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
      for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
      // constrained random
      for (int i = 0; i < 600; i++) begin
         r = $urandom;
         cyc(r[2:0] != 3'd0, r[5:3] == 3'd0, r[8:6] == 3'd0, r[9], r[17:10], r[20:18] == 3'd0);
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule